// File: doc/BRIEF.md
# Register-Mapped Multiply and Multiply-Accumulate Unit

This block is an arithmetic peripheral that sits on a simple synchronous register bus. Software hands it operands by writing 16-bit words and reads the products back as 16-bit words. It contains two independent engines. The first engine multiplies two 16-bit operands. It can treat them as unsigned or signed, and it can either replace its result or add the product into a running accumulator. The second engine multiplies two 32-bit operands and gives a 64-bit product.

The operation is chosen by the address that software uses to write the first operand. Each mode has its own first-operand offset. Writing the second operand starts the computation, and the result can be read on the next cycle. A sum-extension word reports either the sign of the result or the carry out of the last accumulation, depending on the mode. The 16-bit engine's result register can also be written directly, which preloads the accumulator before a chain of multiply-accumulate steps.

The bus has an address, a write strobe, 16-bit write data and a combinational 16-bit read-data port. Every access is a full 16-bit word at an even offset.

Top module: `mac_periph`

## Requirements
- R1: A write of operand 1 of the 16-bit engine latches the operand and picks the mode: 0x130 unsigned multiply, 0x132 signed multiply, 0x134 unsigned accumulate, 0x136 signed accumulate. This write alone leaves every result word unchanged.
- R2: A write to 0x138 (operand 2) runs the latched mode with the latched operand 1. On the next cycle the low result word reads at 0x13A and the high result word at 0x13C.
- R3: In the two plain multiply modes, the 32-bit product replaces the result and both accumulators are cleared, so a following accumulate step returns only its own product.
- R4: In the two accumulate modes, the product is added to the accumulator and the result becomes the new accumulator value. Operand 1 is kept, so repeated operand-2 writes keep accumulating.
- R5: The signed modes treat both 16-bit operands as two's complement. The unsigned modes treat them as plain binary.
- R6: The sum-extension word at 0x13E reads as follows. Unsigned multiply: 0x0000. Signed multiply: 0xFFFF when the result is negative, else 0x0000. Signed accumulate: 0xFFFF when the accumulator is negative, else 0x0000. Unsigned accumulate: the carry out of bit 31 from the last accumulation, as 0x0000 or 0x0001.
- R7: A write to 0x13A preloads the 16-bit engine. The unsigned accumulator takes the value zero-extended. The signed accumulator takes it sign-extended. The result takes the sign-extended value in signed modes and the zero-extended value in unsigned modes. The stored carry is cleared.
- R8: The 32-bit engine's operand 1 is written in two halves. A write to 0x140 loads the low half, clears the high half and selects unsigned. A write to 0x144 does the same but selects signed. A write to 0x142 or 0x146 replaces only the high half.
- R9: A write to 0x150 sets the low half of operand 2 of the 32-bit engine and does not change the product. A write to 0x152 sets the high half and computes the 64-bit product in the latched signedness.
- R10: The 64-bit product reads as four words, least significant first, at 0x154, 0x156, 0x158 and 0x15A. In signed mode it is the two's complement product.
- R11: Reads of any other offset return 0, including the operand offsets. Writes to offsets with no write function (for example 0x13C, or anything outside 0x130..0x152) change nothing.
- R12: After reset all operands, results and accumulators are zero, the 16-bit engine is in unsigned multiply mode, and the 32-bit engine is unsigned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (16) | Byte offset of the word accessed |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |

## Verification
The 16-bit engine is driven with all-ones operands in both unsigned and signed modes. This shows whether the operands are extended correctly, because 0xFFFF times 3 gives a different high word in each mode. A plain multiply followed by accumulate steps shows whether accumulators are cleared or carried over. Accumulating 0xFFFF·0xFFFF twice forces a carry out of bit 31, and a zero product afterwards shows whether that carry is cleared again. Preloading 0x8000 in signed and in unsigned mode separates sign extension from zero extension. The 32-bit engine is tried with all-ones operands, a negative times positive product, and split-half writes, which show that the high half clears on a low write and that the low half survives a high write.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int WORD_W   = 16;
    localparam int NRES_W   = 2 * WORD_W;
    localparam int WIDE_W   = 2 * WORD_W;
    localparam int WRES_W   = 2 * WIDE_W;
    localparam int NPROD_W  = 2 * (WORD_W + 1);
    localparam int WPROD_W  = 2 * (WIDE_W + 1);

    // Register offsets (byte addresses of 16-bit words)
    localparam logic [15:0] OFS_N_UMUL = 16'h0130;
    localparam logic [15:0] OFS_N_SMUL = 16'h0132;
    localparam logic [15:0] OFS_N_UMAC = 16'h0134;
    localparam logic [15:0] OFS_N_SMAC = 16'h0136;
    localparam logic [15:0] OFS_N_OP2  = 16'h0138;
    localparam logic [15:0] OFS_N_LO   = 16'h013A;
    localparam logic [15:0] OFS_N_HI   = 16'h013C;
    localparam logic [15:0] OFS_N_EXT  = 16'h013E;
    localparam logic [15:0] OFS_W_A_LU = 16'h0140;
    localparam logic [15:0] OFS_W_A_HU = 16'h0142;
    localparam logic [15:0] OFS_W_A_LS = 16'h0144;
    localparam logic [15:0] OFS_W_A_HS = 16'h0146;
    localparam logic [15:0] OFS_W_B_L  = 16'h0150;
    localparam logic [15:0] OFS_W_B_H  = 16'h0152;
    localparam logic [15:0] OFS_W_R0   = 16'h0154;
    localparam logic [15:0] OFS_W_R1   = 16'h0156;
    localparam logic [15:0] OFS_W_R2   = 16'h0158;
    localparam logic [15:0] OFS_W_R3   = 16'h015A;

    typedef enum logic [1:0] {
        NM_UMUL = 2'd0,
        NM_SMUL = 2'd1,
        NM_UMAC = 2'd2,
        NM_SMAC = 2'd3
    } nmode_e;

    typedef struct packed {
        logic   ld_op1;
        nmode_e mode;
        logic   ld_op2;
        logic   preload;
    } nreq_t;

    typedef struct packed {
        logic a_lo;
        logic a_sgn;
        logic a_hi;
        logic b_lo;
        logic b_hi;
    } wreq_t;

    typedef enum logic [2:0] {
        RS_NONE = 3'd0,
        RS_NLO  = 3'd1,
        RS_NHI  = 3'd2,
        RS_NEXT = 3'd3,
        RS_W0   = 3'd4,
        RS_W1   = 3'd5,
        RS_W2   = 3'd6,
        RS_W3   = 3'd7
    } rsel_e;

    function automatic logic mode_signed(input nmode_e m);
        return (m == NM_SMUL) || (m == NM_SMAC);
    endfunction

    function automatic logic mode_accum(input nmode_e m);
        return (m == NM_UMAC) || (m == NM_SMAC);
    endfunction

    // Narrow product: operands extended by one bit, then multiplied as signed
    function automatic logic [NRES_W-1:0] nmul(input logic [WORD_W-1:0] a,
                                               input logic [WORD_W-1:0] b,
                                               input logic sgn);
        logic signed [WORD_W:0]    ea;
        logic signed [WORD_W:0]    eb;
        logic signed [NPROD_W-1:0] p;
        ea = $signed({sgn & a[WORD_W-1], a});
        eb = $signed({sgn & b[WORD_W-1], b});
        p  = ea * eb;
        return p[NRES_W-1:0];
    endfunction

    // Wide product, same scheme at double width
    function automatic logic [WRES_W-1:0] wmul(input logic [WIDE_W-1:0] a,
                                               input logic [WIDE_W-1:0] b,
                                               input logic sgn);
        logic signed [WIDE_W:0]    ea;
        logic signed [WIDE_W:0]    eb;
        logic signed [WPROD_W-1:0] p;
        ea = $signed({sgn & a[WIDE_W-1], a});
        eb = $signed({sgn & b[WIDE_W-1], b});
        p  = ea * eb;
        return p[WRES_W-1:0];
    endfunction

endpackage

// File: rtl/mac_decode.sv
module mac_decode
    import mac_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output nreq_t             nreq,
    output wreq_t             wreq,
    output rsel_e             rsel
);

    always_comb begin
        nreq = '{ld_op1: 1'b0, mode: NM_UMUL, ld_op2: 1'b0, preload: 1'b0};
        wreq = '0;
        if (we) begin
            case (addr)
                ADDR_W'(OFS_N_UMUL): begin nreq.ld_op1 = 1'b1; nreq.mode = NM_UMUL; end
                ADDR_W'(OFS_N_SMUL): begin nreq.ld_op1 = 1'b1; nreq.mode = NM_SMUL; end
                ADDR_W'(OFS_N_UMAC): begin nreq.ld_op1 = 1'b1; nreq.mode = NM_UMAC; end
                ADDR_W'(OFS_N_SMAC): begin nreq.ld_op1 = 1'b1; nreq.mode = NM_SMAC; end
                ADDR_W'(OFS_N_OP2):  nreq.ld_op2  = 1'b1;
                ADDR_W'(OFS_N_LO):   nreq.preload = 1'b1;
                ADDR_W'(OFS_W_A_LU): wreq.a_lo = 1'b1;
                ADDR_W'(OFS_W_A_LS): begin wreq.a_lo = 1'b1; wreq.a_sgn = 1'b1; end
                ADDR_W'(OFS_W_A_HU),
                ADDR_W'(OFS_W_A_HS): wreq.a_hi = 1'b1;
                ADDR_W'(OFS_W_B_L):  wreq.b_lo = 1'b1;
                ADDR_W'(OFS_W_B_H):  wreq.b_hi = 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            ADDR_W'(OFS_N_LO):  rsel = RS_NLO;
            ADDR_W'(OFS_N_HI):  rsel = RS_NHI;
            ADDR_W'(OFS_N_EXT): rsel = RS_NEXT;
            ADDR_W'(OFS_W_R0):  rsel = RS_W0;
            ADDR_W'(OFS_W_R1):  rsel = RS_W1;
            ADDR_W'(OFS_W_R2):  rsel = RS_W2;
            ADDR_W'(OFS_W_R3):  rsel = RS_W3;
            default:            rsel = RS_NONE;
        endcase
    end

    // R1 / R11: at most one state-changing action per bus write
    always_comb begin
        a_r1_one_action: assert ($onehot0({nreq.ld_op1, nreq.ld_op2, nreq.preload,
                                           wreq.a_lo, wreq.a_hi, wreq.b_lo, wreq.b_hi}))
            else $error("a_r1_one_action: more than one write action decoded");
    end

endmodule

// File: rtl/mac_narrow.sv
module mac_narrow
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  nreq_t             req,
    input  logic [WORD_W-1:0] wdata,
    output logic [NRES_W-1:0] res_o,
    output logic [WORD_W-1:0] ext_o
);

    logic [WORD_W-1:0] op1_q;
    nmode_e            mode_q;
    logic [NRES_W-1:0] res_q;
    logic [NRES_W-1:0] uacc_q;
    logic [NRES_W-1:0] sacc_q;
    logic              cy_q;

    logic              sgn;
    logic              acc;
    logic [NRES_W-1:0] prod;
    logic [NRES_W:0]   usum;
    logic [NRES_W-1:0] ssum;
    logic [NRES_W-1:0] pre_z;
    logic [NRES_W-1:0] pre_s;

    always_comb begin
        sgn   = mode_signed(mode_q);
        acc   = mode_accum(mode_q);
        prod  = nmul(op1_q, wdata, sgn);
        usum  = {1'b0, uacc_q} + {1'b0, prod};
        ssum  = sacc_q + prod;
        pre_z = {{WORD_W{1'b0}}, wdata};
        pre_s = {{WORD_W{wdata[WORD_W-1]}}, wdata};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op1_q  <= '0;
            mode_q <= NM_UMUL;
            res_q  <= '0;
            uacc_q <= '0;
            sacc_q <= '0;
            cy_q   <= 1'b0;
        end else begin
            if (req.ld_op1) begin
                op1_q  <= wdata;
                mode_q <= req.mode;
            end
            if (req.ld_op2) begin
                if (acc) begin
                    uacc_q <= usum[NRES_W-1:0];
                    cy_q   <= usum[NRES_W];
                    sacc_q <= ssum;
                    res_q  <= sgn ? ssum : usum[NRES_W-1:0];
                end else begin
                    res_q  <= prod;
                    uacc_q <= '0;
                    sacc_q <= '0;
                    cy_q   <= 1'b0;
                end
            end
            if (req.preload) begin
                uacc_q <= pre_z;
                sacc_q <= pre_s;
                res_q  <= sgn ? pre_s : pre_z;
                cy_q   <= 1'b0;
            end
        end
    end

    always_comb begin
        case (mode_q)
            NM_SMUL: ext_o = {WORD_W{res_q[NRES_W-1]}};
            NM_UMAC: ext_o = {{(WORD_W-1){1'b0}}, cy_q};
            NM_SMAC: ext_o = {WORD_W{sacc_q[NRES_W-1]}};
            default: ext_o = '0;
        endcase
    end

    assign res_o = res_q;

    // R3: plain multiply leaves both accumulators and the carry at zero
    a_r3_mul_clears: assert property (@(posedge clk) disable iff (rst)
        (req.ld_op2 && !acc) |=> (uacc_q == '0 && sacc_q == '0 && !cy_q));

    // R4: an unsigned accumulate step never decreases the accumulator unless it carries
    a_r4_mac_grows: assert property (@(posedge clk) disable iff (rst)
        (req.ld_op2 && mode_q == NM_UMAC) |=> (cy_q || uacc_q >= $past(uacc_q)));

    // R7: after a preload the low result word equals the written data
    a_r7_preload_low: assert property (@(posedge clk) disable iff (rst)
        req.preload |=> (res_q[WORD_W-1:0] == $past(wdata)));

    // R11: without a narrow-engine write the result and mode hold
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !(req.ld_op1 || req.ld_op2 || req.preload) |=> ($stable(res_q) && $stable(mode_q)));

endmodule

// File: rtl/mac_wide.sv
module mac_wide
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wreq_t             req,
    input  logic [WORD_W-1:0] wdata,
    output logic [WRES_W-1:0] res_o
);

    logic [WIDE_W-1:0] opa_q;
    logic [WIDE_W-1:0] opb_q;
    logic              sgn_q;
    logic [WRES_W-1:0] res_q;
    logic [WRES_W-1:0] prod;

    always_comb prod = wmul(opa_q, {wdata, opb_q[WORD_W-1:0]}, sgn_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            opa_q <= '0;
            opb_q <= '0;
            sgn_q <= 1'b0;
            res_q <= '0;
        end else begin
            if (req.a_lo) begin
                opa_q <= {{(WIDE_W-WORD_W){1'b0}}, wdata};
                sgn_q <= req.a_sgn;
            end
            if (req.a_hi) opa_q[WIDE_W-1:WORD_W] <= wdata;
            if (req.b_lo) opb_q <= {{(WIDE_W-WORD_W){1'b0}}, wdata};
            if (req.b_hi) begin
                opb_q[WIDE_W-1:WORD_W] <= wdata;
                res_q <= prod;
            end
        end
    end

    assign res_o = res_q;

    // R8: a high-half write keeps the low half of operand 1
    a_r8_hi_keeps_lo: assert property (@(posedge clk) disable iff (rst)
        req.a_hi |=> (opa_q[WORD_W-1:0] == $past(opa_q[WORD_W-1:0])));

    // R9: a low write of operand 2 does not start a product
    a_r9_lo_no_trigger: assert property (@(posedge clk) disable iff (rst)
        (req.b_lo || req.a_lo || req.a_hi) |=> $stable(res_q));

endmodule

// File: rtl/mac_periph.sv
module mac_periph
    import mac_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata
);

    nreq_t             nreq;
    wreq_t             wreq;
    rsel_e             rsel;
    logic [NRES_W-1:0] nres;
    logic [WORD_W-1:0] next;
    logic [WRES_W-1:0] wres;

    mac_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .we   (bus_we),
        .nreq (nreq),
        .wreq (wreq),
        .rsel (rsel)
    );

    mac_narrow u_narrow (
        .clk   (clk),
        .rst   (rst),
        .req   (nreq),
        .wdata (bus_wdata),
        .res_o (nres),
        .ext_o (next)
    );

    mac_wide u_wide (
        .clk   (clk),
        .rst   (rst),
        .req   (wreq),
        .wdata (bus_wdata),
        .res_o (wres)
    );

    always_comb begin
        case (rsel)
            RS_NLO:  bus_rdata = nres[WORD_W-1:0];
            RS_NHI:  bus_rdata = nres[NRES_W-1:WORD_W];
            RS_NEXT: bus_rdata = next;
            RS_W0:   bus_rdata = wres[1*WORD_W-1:0*WORD_W];
            RS_W1:   bus_rdata = wres[2*WORD_W-1:1*WORD_W];
            RS_W2:   bus_rdata = wres[3*WORD_W-1:2*WORD_W];
            RS_W3:   bus_rdata = wres[4*WORD_W-1:3*WORD_W];
            default: bus_rdata = '0;
        endcase
    end

    // R12: one cycle after reset every result word reads zero
    a_r12_reset_zero: assert property (@(posedge clk)
        $past(rst) |-> (nres == '0 && wres == '0 && next == '0));

endmodule

// File: tb/mac_periph_tb.sv
module mac_periph_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic        we = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    mac_periph #(.ADDR_W(16)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_rdata (rdata)
    );

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0; addr = 16'h0000; wdata = 16'h0000;
    endtask

    task automatic rd(input logic [15:0] a, input logic [15:0] exp, input string tag);
        logic [15:0] got;
        @(negedge clk);
        addr = a; we = 1'b0;
        #1;
        got = rdata;
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: read @%h got %h expected %h", tag, a, got, exp);
        end
    endtask

    task automatic t_reset;
        rd(16'h013A, 16'h0000, "R12");
        rd(16'h013C, 16'h0000, "R12");
        rd(16'h013E, 16'h0000, "R12");
        rd(16'h0154, 16'h0000, "R12");
        rd(16'h015A, 16'h0000, "R12");
    endtask

    task automatic t_umul;
        wr(16'h0130, 16'hFFFF);
        wr(16'h0138, 16'hFFFF);            // 0xFFFF*0xFFFF = 0xFFFE0001
        rd(16'h013A, 16'h0001, "R2");
        rd(16'h013C, 16'hFFFE, "R2");
        rd(16'h013E, 16'h0000, "R6");
    endtask

    task automatic t_smul;
        wr(16'h0132, 16'hFFFF);
        wr(16'h0138, 16'h0003);            // -1*3 = 0xFFFFFFFD
        rd(16'h013A, 16'hFFFD, "R5");
        rd(16'h013C, 16'hFFFF, "R5");
        rd(16'h013E, 16'hFFFF, "R6");
        wr(16'h0132, 16'h7FFF);
        wr(16'h0138, 16'h0002);            // 0x7FFF*2 = 0x0000FFFE
        rd(16'h013A, 16'hFFFE, "R5");
        rd(16'h013C, 16'h0000, "R5");
        rd(16'h013E, 16'h0000, "R6");
    endtask

    task automatic t_clear_accum;
        wr(16'h0130, 16'd100);
        wr(16'h0138, 16'd200);             // 20000 = 0x4E20
        rd(16'h013A, 16'h4E20, "R3");
        wr(16'h0134, 16'd3);               // select unsigned accumulate
        rd(16'h013A, 16'h4E20, "R1");      // op1 write alone: no change
        wr(16'h0138, 16'd5);               // accumulators were cleared: 15
        rd(16'h013A, 16'd15, "R3");
        rd(16'h013C, 16'h0000, "R3");
        wr(16'h0138, 16'd7);               // 15 + 21 = 36
        rd(16'h013A, 16'd36, "R4");
    endtask

    task automatic t_carry;
        wr(16'h0130, 16'h0000);
        wr(16'h0138, 16'h0000);            // clear accumulators
        wr(16'h0134, 16'hFFFF);
        wr(16'h0138, 16'hFFFF);            // acc = 0xFFFE0001
        rd(16'h013E, 16'h0000, "R6");
        wr(16'h0138, 16'hFFFF);            // 0x1FFFC0002 -> carry
        rd(16'h013A, 16'h0002, "R4");
        rd(16'h013C, 16'hFFFC, "R4");
        rd(16'h013E, 16'h0001, "R6");
        wr(16'h0138, 16'h0000);            // add 0, no carry
        rd(16'h013E, 16'h0000, "R6");
        rd(16'h013C, 16'hFFFC, "R4");
    endtask

    task automatic t_preload;
        wr(16'h0136, 16'h0002);
        wr(16'h013A, 16'h8000);            // signed preload: 0xFFFF8000
        rd(16'h013A, 16'h8000, "R7");
        rd(16'h013C, 16'hFFFF, "R7");
        rd(16'h013E, 16'hFFFF, "R6");
        wr(16'h0138, 16'h4000);            // + 0x8000 -> 0
        rd(16'h013A, 16'h0000, "R7");
        rd(16'h013C, 16'h0000, "R7");
        rd(16'h013E, 16'h0000, "R6");
        wr(16'h0134, 16'h0001);
        wr(16'h013A, 16'h8000);            // unsigned preload: 0x00008000
        rd(16'h013C, 16'h0000, "R7");
        wr(16'h0138, 16'h8000);            // 0x8000+0x8000 = 0x10000
        rd(16'h013A, 16'h0000, "R7");
        rd(16'h013C, 16'h0001, "R7");
    endtask

    task automatic t_wide_unsigned;
        wr(16'h0140, 16'hFFFF);
        wr(16'h0142, 16'hFFFF);
        wr(16'h0150, 16'hFFFF);
        wr(16'h0152, 16'hFFFF);            // 0xFFFFFFFE00000001
        rd(16'h0154, 16'h0001, "R10");
        rd(16'h0156, 16'h0000, "R10");
        rd(16'h0158, 16'hFFFE, "R10");
        rd(16'h015A, 16'hFFFF, "R10");
        wr(16'h0140, 16'h1234);
        wr(16'h0142, 16'h0001);            // op1 = 0x00011234
        wr(16'h0150, 16'h0010);
        wr(16'h0152, 16'h0000);            // 0x112340
        rd(16'h0154, 16'h2340, "R8");
        rd(16'h0156, 16'h0011, "R8");
    endtask

    task automatic t_wide_signed;
        wr(16'h0144, 16'hFFFE);
        wr(16'h0146, 16'hFFFF);            // -2
        wr(16'h0150, 16'h0003);
        wr(16'h0152, 16'h0000);            // -6
        rd(16'h0154, 16'hFFFA, "R10");
        rd(16'h0156, 16'hFFFF, "R10");
        rd(16'h0158, 16'hFFFF, "R10");
        rd(16'h015A, 16'hFFFF, "R10");
        wr(16'h0144, 16'h0005);            // high half cleared -> 5
        wr(16'h0150, 16'h0007);
        rd(16'h0154, 16'hFFFA, "R9");      // low op2 write: no product yet
        wr(16'h0152, 16'h0000);            // 35
        rd(16'h0154, 16'h0023, "R8");
        rd(16'h015A, 16'h0000, "R8");
    endtask

    task automatic t_ignored;
        rd(16'h0130, 16'h0000, "R11");
        rd(16'h0138, 16'h0000, "R11");
        rd(16'h0142, 16'h0000, "R11");
        rd(16'h015C, 16'h0000, "R11");
        wr(16'h013C, 16'hAAAA);
        wr(16'h0160, 16'h5555);
        wr(16'h0154, 16'h1111);
        rd(16'h013A, 16'h0000, "R11");     // still 0x00010000 from preload test
        rd(16'h013C, 16'h0001, "R11");
        rd(16'h0154, 16'h0023, "R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_umul();
        t_smul();
        t_clear_accum();
        t_carry();
        t_preload();
        t_wide_unsigned();
        t_wide_signed();
        t_ignored();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule